// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block holds the interrupt enable register and produces the interrupt status code for an enhanced UART. The CPU writes an eight-bit enable register, writes a one-bit enhanced-feature gate, and reads a six-bit status code. Seven event sources each set their own pending flag: line-status error, receive data ready, transmit empty and modem-status change arrive as one-cycle pulses. Rising edges on the RTS and CTS level inputs are synchronised and then detected. A small matcher compares each received character against one or two programmed Xoff characters and signals an Xoff event.

Pending flags are latched whatever the enables are, but only enabled flags drive the interrupt line and the status code. A status read reports the highest-priority enabled pending source and clears that source alone, so repeated reads drain the pending sources in priority order. A sleep request takes effect only when sleep is enabled and no enabled interrupt is pending. A pending interrupt ends sleep.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq` is 0, `isr_code` is 000001 (nothing pending) and `sleep_active` is 0.
- R2: Enable bits 0 (receive data), 1 (transmit empty), 2 (line status) and 3 (modem status) take every write. Bits 4 (sleep), 5 (Xoff), 6 (RTS) and 7 (CTS) change only while the gate bit, written through `efr_wr`/`efr_wdata`, is 1. Otherwise they keep their value.
- R3: With several enabled sources pending, `isr_code` gives the highest one, in this order from highest to lowest: line status 000110, receive data 000100, transmit empty 000010, modem status 000000, Xoff 010000, CTS or RTS 100000. `irq` is 1 exactly when some enabled source is pending.
- R4: A pending source whose enable bit is 0 neither raises `irq` nor shows in `isr_code`. It becomes visible once its enable bit is set.
- R5: A status read clears only the source it reports, and the next lower enabled pending source appears on the following read.
- R6: If a source's event arrives in the same cycle as the read that clears that source, the source stays pending.
- R7: The RTS and CTS interrupts are set only by a 0-to-1 transition of the input. An input held high does not set them again after a read.
- R8: In single-character mode (`xoff_pair_mode`=0), a received character equal to `xoff_char1` sets the Xoff interrupt while `sw_flow_en` is 1. With `sw_flow_en` at 0, no match occurs.
- R9: In two-character mode, the Xoff interrupt is set only when a character equal to `xoff_char2` directly follows a character equal to `xoff_char1`. Any other character in between, or `xoff_char2` alone, does not set it.
- R10: `sleep_active` becomes 1 one cycle after `sleep_req` is 1 while enable bit 4 is 1 and `irq` is 0. It drops to 0 while any enabled interrupt is pending. Entering or leaving sleep leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register contents |
| efr_wr | input | 1 | Gate bit write strobe |
| efr_wdata | input | 1 | Gate bit write value |
| isr_rd | input | 1 | Status read strobe; clears the reported source |
| isr_code | output | 6 | Highest enabled pending source code |
| irq | output | 1 | Interrupt line |
| ev_line_err | input | 1 | Line-status error event pulse |
| ev_rx_ready | input | 1 | Receive data ready event pulse |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_modem | input | 1 | Modem-status change event pulse |
| rts_in | input | 1 | RTS level input |
| cts_in | input | 1 | CTS level input |
| sw_flow_en | input | 1 | Software flow control enable |
| xoff_pair_mode | input | 1 | 1: two-character Xoff sequence, 0: single character |
| xoff_char1 | input | 8 | First (or only) Xoff character |
| xoff_char2 | input | 8 | Second Xoff character |
| rx_char_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| sleep_req | input | 1 | Sleep request level |
| sleep_active | output | 1 | Sleep state |

## Verification
The assertions assume that every input is driven to a known value from reset onward, that event inputs and `isr_rd` are single-cycle strobes, and that RTS and CTS are held low when reset is released, so that no edge is seen at reset. The bench drives all inputs on the falling clock edge from known values and pulses each strobe for exactly one cycle. It raises RTS and CTS only after reset and holds them long enough for the synchroniser to pass the change. The lower-source sweeps cover all sixteen event combinations and all sixteen enable masks, and each expected code is taken arithmetically from the lowest set priority index.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC   = 7;
   localparam int CODE_W = 6;
   localparam int IER_W  = 8;

   // Source indices, lowest index is highest priority
   localparam int S_LINE  = 0;
   localparam int S_RX    = 1;
   localparam int S_TX    = 2;
   localparam int S_MODEM = 3;
   localparam int S_XOFF  = 4;
   localparam int S_CTS   = 5;
   localparam int S_RTS   = 6;

   localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

   function automatic logic [CODE_W-1:0] src_code(input int idx);
      case (idx)
         S_LINE:  return 6'b000110;
         S_RX:    return 6'b000100;
         S_TX:    return 6'b000010;
         S_MODEM: return 6'b000000;
         S_XOFF:  return 6'b010000;
         default: return 6'b100000;
      endcase
   endfunction
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
   parameter int N           = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] lvl_s;
   logic [N-1:0] prev;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad
         $error("SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign lvl_s = lvl;
      end else begin : g_sync
         logic [N-1:0] st [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= lvl;
               for (int i = 1; i < SYNC_STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign lvl_s = st[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl_s;
   end

   assign rise = lvl_s & ~prev;

   // A detected edge never lasts two cycles
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/xoff_seq_match.sv
module xoff_seq_match #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_en,
   input  logic              pair_mode,
   input  logic              valid,
   input  logic [CHAR_W-1:0] ch,
   input  logic [CHAR_W-1:0] c1,
   input  logic [CHAR_W-1:0] c2,
   output logic              match
);
   generate
      if (CHAR_W < 5 || CHAR_W > 8) begin : g_bad
         $error("CHAR_W must be 5..8");
      end
   endgenerate

   logic armed;
   logic hit1, hit2;

   assign hit1 = (ch == c1);
   assign hit2 = (ch == c2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed <= 1'b0;
      else if (!flow_en)         armed <= 1'b0;
      else if (valid)            armed <= pair_mode & hit1;
   end

   always_comb begin
      match = 1'b0;
      if (flow_en && valid)
         match = pair_mode ? (armed & hit2) : hit1;
   end

   // The first character of a pair arms the matcher only through a valid strobe
   assert_arm_by_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(valid) && $past(pair_mode));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
         end
      end
   endgenerate

   // A new event outranks a clear of the same source
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((pend & $past(set)) == $past(set)));
   // A flag only drops when a read targeted it
   assert_clear_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend & $past(pend) & ~$past(clr)) == '0));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
   import uart_irq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0]      req,
   output logic [N-1:0]      grant,
   output logic [CODE_W-1:0] code
);
   always_comb begin
      grant = '0;
      code  = CODE_NONE;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            code     = src_code(i);
         end
      end
   end

   always_comb begin
      assert_grant_onehot_R3: assert ($onehot0(grant));
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ier_wr,
   input  logic [7:0]        ier_wdata,
   output logic [7:0]        ier_rdata,
   input  logic              efr_wr,
   input  logic              efr_wdata,
   input  logic              isr_rd,
   output logic [5:0]        isr_code,
   output logic              irq,
   input  logic              ev_line_err,
   input  logic              ev_rx_ready,
   input  logic              ev_tx_empty,
   input  logic              ev_modem,
   input  logic              rts_in,
   input  logic              cts_in,
   input  logic              sw_flow_en,
   input  logic              xoff_pair_mode,
   input  logic [CHAR_W-1:0] xoff_char1,
   input  logic [CHAR_W-1:0] xoff_char2,
   input  logic              rx_char_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              sleep_req,
   output logic              sleep_active
);
   localparam int LOW_W = IER_W / 2;

   logic [IER_W-1:0] ier_q;
   logic             gate_q;
   logic [1:0]       hs_rise;
   logic             xoff_hit;
   logic [NSRC-1:0]  set_v, clr_v, pend, en_v, grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else if (efr_wr) gate_q <= efr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q <= '0;
      end else if (ier_wr) begin
         ier_q[LOW_W-1:0] <= ier_wdata[LOW_W-1:0];
         if (gate_q) ier_q[IER_W-1:LOW_W] <= ier_wdata[IER_W-1:LOW_W];
      end
   end
   assign ier_rdata = ier_q;

   irq_rise_det #(.N(2), .SYNC_STAGES(SYNC_STAGES)) u_rise (
      .clk(clk), .rst_n(rst_n), .lvl({cts_in, rts_in}), .rise(hs_rise));

   xoff_seq_match #(.CHAR_W(CHAR_W)) u_xoff (
      .clk(clk), .rst_n(rst_n), .flow_en(sw_flow_en), .pair_mode(xoff_pair_mode),
      .valid(rx_char_valid), .ch(rx_char), .c1(xoff_char1), .c2(xoff_char2),
      .match(xoff_hit));

   always_comb begin
      set_v          = '0;
      set_v[S_LINE]  = ev_line_err;
      set_v[S_RX]    = ev_rx_ready;
      set_v[S_TX]    = ev_tx_empty;
      set_v[S_MODEM] = ev_modem;
      set_v[S_XOFF]  = xoff_hit;
      set_v[S_CTS]   = hs_rise[1];
      set_v[S_RTS]   = hs_rise[0];
      en_v           = '0;
      en_v[S_LINE]   = ier_q[2];
      en_v[S_RX]     = ier_q[0];
      en_v[S_TX]     = ier_q[1];
      en_v[S_MODEM]  = ier_q[3];
      en_v[S_XOFF]   = ier_q[5];
      en_v[S_CTS]    = ier_q[7];
      en_v[S_RTS]    = ier_q[6];
   end

   irq_pend_bank #(.N(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend));

   irq_prio_sel #(.N(NSRC)) u_prio (
      .req(pend & en_v), .grant(grant), .code(isr_code));

   assign clr_v = isr_rd ? grant : '0;
   assign irq   = |(pend & en_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sleep_active <= 1'b0;
      else        sleep_active <= sleep_req & ier_q[4] & ~irq;
   end

   assert_upper_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && !gate_q) |=> ier_q[IER_W-1:LOW_W] == $past(ier_q[IER_W-1:LOW_W]));
   assert_code_vs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_code == CODE_NONE) == !irq);
   assert_one_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      isr_rd |=> ($countones(pend) + 1 >= $countones($past(pend))));
   assert_no_sleep_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !sleep_active);
   assert_xoff_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_flow_en |-> !xoff_hit);
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
   logic       clk = 0, rst_n = 0;
   logic       ier_wr = 0, efr_wr = 0, efr_wdata = 0, isr_rd = 0;
   logic [7:0] ier_wdata = 0, ier_rdata;
   logic [5:0] isr_code;
   logic       irq, sleep_active;
   logic       ev_line_err = 0, ev_rx_ready = 0, ev_tx_empty = 0, ev_modem = 0;
   logic       rts_in = 0, cts_in = 0, sw_flow_en = 0, xoff_pair_mode = 0;
   logic [7:0] xoff_char1 = 0, xoff_char2 = 0, rx_char = 0;
   logic       rx_char_valid = 0, sleep_req = 0;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   uart_irq_ctrl u0 (.*);

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ier(logic [7:0] v);
      ier_wr = 1; ier_wdata = v; cyc(1); ier_wr = 0;
   endtask

   task automatic wr_gate(logic v);
      efr_wr = 1; efr_wdata = v; cyc(1); efr_wr = 0;
   endtask

   // bit0 line, bit1 rx, bit2 tx, bit3 modem
   task automatic pulse(logic [3:0] m);
      {ev_modem, ev_tx_empty, ev_rx_ready, ev_line_err} = m;
      cyc(1);
      {ev_modem, ev_tx_empty, ev_rx_ready, ev_line_err} = 4'b0;
   endtask

   task automatic rd(output logic [5:0] c);
      c = isr_code; isr_rd = 1; cyc(1); isr_rd = 0;
   endtask

   task automatic send(logic [7:0] ch);
      rx_char = ch; rx_char_valid = 1; cyc(1); rx_char_valid = 0;
   endtask

   function automatic int low_code(logic [3:0] m);
      if (m[0]) return 6;
      if (m[1]) return 4;
      if (m[2]) return 2;
      if (m[3]) return 0;
      return 1;
   endfunction

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
   end

   initial begin
      logic [5:0] c;
      cyc(2); rst_n = 1; cyc(1);
      // R1 reset state
      chk("R1 ier", ier_rdata, 0);
      chk("R1 irq", irq, 0);
      chk("R1 code", isr_code, 1);
      chk("R1 sleep", sleep_active, 0);

      // R2 gate bit
      wr_ier(8'hFF);          chk("R2 gate0 write", ier_rdata, 8'h0F);
      wr_gate(1); wr_ier(8'hFF); chk("R2 gate1 write", ier_rdata, 8'hFF);
      wr_gate(0); wr_ier(8'h00); chk("R2 gate0 clear", ier_rdata, 8'hF0);
      wr_gate(1); wr_ier(8'h0F); chk("R2 gate1 lower", ier_rdata, 8'h0F);

      // R3/R5 sweep all event combinations, drain in order
      for (int m = 0; m < 16; m++) begin
         logic [3:0] rem;
         rem = 4'(m);
         pulse(rem);
         chk("R3 irq", irq, int'(rem != 0));
         for (int k = 0; k < 4; k++) begin
            if (rem != 0) begin
               rd(c);
               chk("R3 code order", c, low_code(rem));
               rem = rem & (rem - 4'd1);
            end
         end
         chk("R5 drained", isr_code, 1);
      end

      // R4 enable mask sweep with all four pending
      wr_ier(8'h00); pulse(4'hF);
      chk("R4 masked irq", irq, 0);
      chk("R4 masked code", isr_code, 1);
      for (int e = 0; e < 16; e++) begin
         logic [3:0] en;
         en = 4'(e);
         wr_ier({4'b0, en[3], en[0], en[2], en[1]});
         chk("R4 code", isr_code, low_code(en));
         chk("R4 irq", irq, int'(en != 0));
      end
      wr_ier(8'h0F);
      for (int k = 0; k < 4; k++) rd(c);
      chk("R5 cleared", isr_code, 1);

      // R6 event in same cycle as clearing read
      pulse(4'b0010);
      ev_rx_ready = 1; rd(c); ev_rx_ready = 0;
      chk("R6 read code", c, 4);
      chk("R6 still pending", isr_code, 4);
      rd(c); chk("R6 cleared after", isr_code, 1);

      // R7 RTS/CTS rising edges
      wr_ier(8'hC0);
      rts_in = 1; cyc(5);
      chk("R7 rts rise", isr_code, 6'h20);
      rd(c); cyc(5);
      chk("R7 rts held", isr_code, 1);
      rts_in = 0; cts_in = 1; cyc(5);
      chk("R7 cts rise", isr_code, 6'h20);
      rd(c); cyc(3);
      chk("R7 cts held", irq, 0);
      cts_in = 0; cyc(4);

      // R8 single-character Xoff
      wr_ier(8'h20); xoff_char1 = 8'h13; xoff_char2 = 8'h93;
      sw_flow_en = 1; xoff_pair_mode = 0;
      send(8'h41); chk("R8 other char", isr_code, 1);
      send(8'h13); chk("R8 match", isr_code, 6'h10);
      rd(c);
      sw_flow_en = 0; send(8'h13);
      chk("R8 flow off", isr_code, 1);

      // R9 two-character Xoff sequence
      sw_flow_en = 1; xoff_pair_mode = 1; xoff_char1 = 8'h11; xoff_char2 = 8'h13;
      send(8'h11); chk("R9 first only", isr_code, 1);
      send(8'h13); chk("R9 pair", isr_code, 6'h10);
      rd(c);
      send(8'h11); send(8'h41); send(8'h13);
      chk("R9 broken pair", isr_code, 1);
      send(8'h13); chk("R9 second alone", isr_code, 1);
      sw_flow_en = 0;

      // R10 sleep
      wr_ier(8'h11); sleep_req = 1; cyc(2);
      chk("R10 sleep entered", sleep_active, 1);
      chk("R10 ier kept", ier_rdata, 8'h11);
      pulse(4'b0010); cyc(1);
      chk("R10 woken", sleep_active, 0);
      cyc(3);
      chk("R10 refused", sleep_active, 0);
      rd(c); cyc(2);
      chk("R10 re-entered", sleep_active, 1);
      sleep_req = 0; cyc(2);
      chk("R10 left", sleep_active, 0);
      chk("R10 ier after", ier_rdata, 8'h11);

      summary();
   end
endmodule